// File: doc/BRIEF.md
# Signed Compare-to-Condition-Field Unit

This block executes the register-register signed compare of a 64-bit RISC core whose instruction bits are numbered from the most significant end (bit 0 is the MSB). Each cycle it may accept one 32-bit instruction word with in_valid. Along with it come the two 64-bit source values, already read from the register file, and the current sticky summary-overflow bit. The block decodes the word and passes the two source register specifiers out as read addresses. A width bit selects one of two compares. The first compares the sign-extended low 32-bit words. The second compares the full 64-bit values. Both compares are signed.

The result is a 4-bit nibble: less-than, greater-than, equal, and a copy of the overflow bit. The block keeps a 32-bit condition register made of eight 4-bit fields. The nibble overwrites only the one field that the instruction selects, and the write is registered. A word that is not this compare raises an illegal flag in the same cycle and changes nothing.

Top module: `scmp_unit`

## Requirements
- R1: A word is a legal compare when bits 31:26 of instr (MSB-numbered bits 0–5) equal 31 and bits 10:1 (MSB-numbered bits 21–30) equal 0, so the base word is 0x7C000000. Bit 22 (reserved) and bit 0 are ignored.
- R2: When the width bit instr[21] is 0, the low 32 bits of each operand are sign-extended to 64 bits and then compared. The upper 32 bits have no effect.
- R3: When instr[21] is 1, the full 64-bit operands are compared as signed two's-complement values.
- R4: In a written field, exactly one of LT, GT and EQ is set, and it is the one that matches the signed relation of a to b.
- R5: The SO bit of the written field equals so_in as sampled with the instruction, whatever the compare outcome.
- R6: instr[25:23] selects field n (0–7). Field n occupies cr_out[31-4n -: 4] with LT at the top, then GT, EQ and SO. Field 0 is therefore cr_out[31:28]. All other condition bits stay unchanged.
- R7: ra_addr equals instr[20:16] and rb_addr equals instr[15:11], combinationally.
- R8: illegal is high in the same cycle when in_valid is high and the word is not a legal compare. Such a word leaves cr_out and done unaffected. When in_valid is low, illegal is low and cr_out holds.
- R9: done is high for exactly the cycle after an accepted compare. The new cr_out value is visible in that same cycle.
- R10: A synchronous active-high reset clears cr_out to zero and done to 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| opa | input | 64 | Value of source register A |
| opb | input | 64 | Value of source register B |
| so_in | input | 1 | Current sticky summary-overflow bit |
| ra_addr | output | 5 | Read address for source A |
| rb_addr | output | 5 | Read address for source B |
| illegal | output | 1 | Accepted word is not a compare |
| done | output | 1 | Compare was written in the previous cycle |
| cr_out | output | 32 | Condition register |

## Verification
The case hardest to reach from the ports is a narrow compare in which the upper halves would decide the outcome and the low halves decide otherwise. One example is operands with equal low words but different upper words, which must report EQ. Another is a low word of 0x80000000 set against a large positive upper half. The sweep crosses a value set built around the extreme values of both widths with itself, in both widths and in all eight fields. It carries a bench-side model of the whole register, so every write also shows whether the other seven fields are disturbed.

// File: rtl/scmp_pkg.sv
package scmp_pkg;
    localparam int XLEN   = 64;
    localparam int WORD   = 32;
    localparam int IW     = 32;
    localparam int REGW   = 5;
    localparam int XOW    = 10;
    localparam int OPW    = 6;
    localparam int NFIELD = 8;
    localparam int FW     = 4;
    localparam int CRW    = NFIELD * FW;
    localparam int SELW   = $clog2(NFIELD);

    localparam logic [OPW-1:0] OP_PRIMARY = OPW'(31);
    localparam logic [XOW-1:0] OP_EXT     = XOW'(0);

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } crf_t;

    typedef struct packed {
        logic            legal;
        logic [SELW-1:0] sel;
        logic            wide;
        logic [REGW-1:0] ra;
        logic [REGW-1:0] rb;
    } dec_t;

    // LSB position of field sel inside the condition register (field 0 on top)
    function automatic int field_lsb(logic [SELW-1:0] sel);
        return CRW - FW * (int'(sel) + 1);
    endfunction

    function automatic logic [CRW-1:0] field_mask(logic [SELW-1:0] sel);
        logic [CRW-1:0] base;
        base = {{(CRW-FW){1'b0}}, {FW{1'b1}}};
        return base << field_lsb(sel);
    endfunction

    function automatic crf_t field_get(logic [CRW-1:0] cr, logic [SELW-1:0] sel);
        logic [CRW-1:0] t;
        t = cr >> field_lsb(sel);
        return crf_t'(t[FW-1:0]);
    endfunction
endpackage

// File: rtl/scmp_decode.sv
module scmp_decode
    import scmp_pkg::*;
(
    input  logic [IW-1:0] instr,
    output dec_t          dec
);
    logic           unused_bits;
    logic [OPW-1:0] primary;
    logic [XOW-1:0] ext;

    // MSB-first bit k of the word lives at instr[IW-1-k]
    assign primary     = instr[IW-1 -: OPW];
    assign ext         = instr[IW-22 -: XOW];
    assign unused_bits = ^{instr[IW-10], instr[0]};

    always_comb begin
        dec.legal = (primary == OP_PRIMARY) && (ext == OP_EXT);
        dec.sel   = instr[IW-7 -: SELW];
        dec.wide  = instr[IW-11];
        dec.ra    = instr[IW-12 -: REGW];
        dec.rb    = instr[IW-17 -: REGW];
    end
endmodule

// File: rtl/scmp_compare.sv
module scmp_compare
    import scmp_pkg::*;
#(
    parameter int DW = XLEN,
    parameter int NW = WORD
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          wide,
    input  logic          so,
    output crf_t          res
);
    logic [DW-1:0] ea, eb;
    logic          less, same;

    always_comb begin
        if (wide) begin
            ea = a;
            eb = b;
        end else begin
            ea = {{(DW-NW){a[NW-1]}}, a[NW-1:0]};
            eb = {{(DW-NW){b[NW-1]}}, b[NW-1:0]};
        end
        less   = $signed(ea) < $signed(eb);
        same   = (ea == eb);
        res.lt = less;
        res.eq = same;
        res.gt = !less && !same;
        res.so = so;
    end
endmodule

// File: rtl/scmp_crfile.sv
module scmp_crfile
    import scmp_pkg::*;
#(
    parameter int NF = NFIELD
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [SELW-1:0]      sel,
    input  crf_t                 wdata,
    output logic [NF*FW-1:0]     cr
);
    for (genvar g = 0; g < NF; g++) begin : g_field
        crf_t fld;
        always_ff @(posedge clk) begin
            if (rst)
                fld <= '0;
            else if (we && sel == SELW'(g))
                fld <= wdata;
        end
        assign cr[NF*FW-1-FW*g -: FW] = fld;
    end
endmodule

// File: rtl/scmp_unit.sv
module scmp_unit
    import scmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IW-1:0]    instr,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    input  logic             so_in,
    output logic [REGW-1:0]  ra_addr,
    output logic [REGW-1:0]  rb_addr,
    output logic             illegal,
    output logic             done,
    output logic [CRW-1:0]   cr_out
);
    dec_t dec;
    crf_t res;
    logic accept;

    scmp_decode u_dec (.instr(instr), .dec(dec));

    scmp_compare #(.DW(XLEN), .NW(WORD)) u_cmp (
        .a(opa), .b(opb), .wide(dec.wide), .so(so_in), .res(res)
    );

    assign accept  = in_valid && dec.legal;
    assign illegal = in_valid && !dec.legal;
    assign ra_addr = dec.ra;
    assign rb_addr = dec.rb;

    scmp_crfile #(.NF(NFIELD)) u_cr (
        .clk(clk), .rst(rst), .we(accept), .sel(dec.sel), .wdata(res), .cr(cr_out)
    );

    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= accept;
    end
endmodule

// File: rtl/scmp_unit_chk.sv
module scmp_unit_chk
    import scmp_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [IW-1:0]   instr,
    input logic [XLEN-1:0] opa,
    input logic [XLEN-1:0] opb,
    input logic            so_in,
    input logic            illegal,
    input logic            done,
    input logic [CRW-1:0]  cr_out
);
    logic            wr;
    logic [SELW-1:0] sel;
    logic            wide;
    logic            unused_chk;

    assign wr         = in_valid && !illegal;
    assign sel        = instr[IW-7 -: SELW];
    assign wide       = instr[IW-11];
    assign unused_chk = ^{instr[IW-1 -: 6], instr[IW-10], instr[IW-12:0]};

    p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        wr |=> $countones({field_get(cr_out, $past(sel)).lt,
                           field_get(cr_out, $past(sel)).gt,
                           field_get(cr_out, $past(sel)).eq}) == 1);

    p_so_copy_r5: assert property (@(posedge clk) disable iff (rst)
        wr |=> field_get(cr_out, $past(sel)).so == $past(so_in));

    p_others_kept_r6: assert property (@(posedge clk) disable iff (rst)
        wr |=> ((cr_out & ~field_mask($past(sel))) ==
                ($past(cr_out) & ~field_mask($past(sel)))));

    p_wide_lt_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && wide) |=> field_get(cr_out, $past(sel)).lt ==
                         ($signed($past(opa)) < $signed($past(opb))));

    p_narrow_eq_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && !wide) |=> field_get(cr_out, $past(sel)).eq ==
                          ($past(opa[WORD-1:0]) == $past(opb[WORD-1:0])));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(cr_out));

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !illegal);

    p_done_r9: assert property (@(posedge clk) disable iff (rst)
        wr |=> done);

    p_done_src_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(wr));

    p_reset_r10: assert property (@(posedge clk)
        $past(rst) |-> (cr_out == '0 && !done));
endmodule

bind scmp_unit scmp_unit_chk u_chk (.*);

// File: tb/scmp_unit_test.sv
module scmp_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr;
    logic [63:0] opa, opb;
    logic        so_in;
    logic [4:0]  ra_addr, rb_addr;
    logic        illegal, done;
    logic [31:0] cr_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_cr;
    logic [63:0] vals [10];

    always #(CLK_PERIOD/2) clk = ~clk;

    scmp_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .opa(opa), .opb(opb), .so_in(so_in), .ra_addr(ra_addr),
        .rb_addr(rb_addr), .illegal(illegal), .done(done), .cr_out(cr_out)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int f, bit l, int ra, int rb, bit resv, bit rc);
        return {6'd31, 3'(f), resv, l, 5'(ra), 5'(rb), 10'd0, rc};
    endfunction

    function automatic logic [3:0] model(logic [63:0] a, logic [63:0] b, bit l, bit so);
        longint sa, sb;
        if (l) begin
            sa = longint'(a);
            sb = longint'(b);
        end else begin
            sa = longint'(int'(a[31:0]));
            sb = longint'(int'(b[31:0]));
        end
        return {sa < sb, sa > sb, sa == sb, so};
    endfunction

    // drive at negedge, check next negedge after one rising edge
    task automatic issue(logic [31:0] w, logic [63:0] a, logic [63:0] b, bit so,
                         bit legal, int f, bit l);
        logic [3:0] nib;
        in_valid = 1'b1; instr = w; opa = a; opb = b; so_in = so;
        #1;
        check("R1/R8 illegal", illegal, !legal);
        check("R7 ra_addr", ra_addr, w[20:16]);
        check("R7 rb_addr", rb_addr, w[15:11]);
        if (legal) begin
            nib = model(a, b, l, so);
            for (int k = 0; k < 4; k++) exp_cr[31 - 4*f - k] = nib[3 - k];
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 done", done, legal);
        check(l ? "R3/R4/R5/R6 cr_out" : "R2/R4/R5/R6 cr_out", cr_out, exp_cr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        vals[0] = 64'h0;
        vals[1] = 64'h1;
        vals[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        vals[3] = 64'h0000_0000_7FFF_FFFF;
        vals[4] = 64'h0000_0000_8000_0000;
        vals[5] = 64'h7FFF_FFFF_FFFF_FFFF;
        vals[6] = 64'h8000_0000_0000_0000;
        vals[7] = 64'hDEAD_0000_0000_0005;
        vals[8] = 64'h1234_0000_0000_0005;
        vals[9] = 64'h7FFF_0000_8000_0000;

        rst = 1'b1; in_valid = 1'b0; instr = '0; opa = '0; opb = '0; so_in = 1'b0;
        exp_cr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 reset cr_out", cr_out, 32'h0);
        check("R10 reset done", done, 1'b0);

        // R2 R3 R4 R5 R6: sweep fields, widths, operand pairs
        for (int f = 0; f < 8; f++)
            for (int l = 0; l < 2; l++)
                for (int i = 0; i < 10; i++)
                    for (int j = 0; j < 10; j++)
                        issue(mk(f, l[0], i + 3*j, 31 - i - j, 1'b0, 1'b0),
                              vals[i], vals[j], ((i + j + f) % 3) == 0, 1'b1, f, l[0]);

        // R2 corner: upper halves differ, low words equal -> EQ in field 2
        issue(mk(2, 1'b0, 1, 2, 1'b0, 1'b0), vals[7], vals[8], 1'b0, 1'b1, 2, 1'b0);
        check("R2 upper-differ EQ", cr_out[23:20], 4'b0010);
        // R3 extreme: most negative vs most positive, field 7
        issue(mk(7, 1'b1, 3, 4, 1'b0, 1'b0), vals[6], vals[5], 1'b1, 1'b1, 7, 1'b1);
        check("R3 min<max LT", cr_out[3:0], 4'b1001);
        // R1 reserved bit and bit 31 ignored
        issue(mk(0, 1'b1, 5, 6, 1'b1, 1'b1), vals[5], vals[6], 1'b0, 1'b1, 0, 1'b1);
        check("R1 reserved ignored GT", cr_out[31:28], 4'b0100);

        // R8: not a compare (wrong primary opcode, nonzero extended opcode)
        issue({6'd30, 26'd0}, vals[0], vals[1], 1'b1, 1'b0, 0, 1'b0);
        issue(mk(3, 1'b0, 1, 1, 1'b0, 1'b0) | 32'h0000_0040, vals[0], vals[1], 1'b1, 1'b0, 3, 1'b0);
        issue(mk(3, 1'b0, 1, 1, 1'b0, 1'b0) | 32'h0000_0400, vals[2], vals[1], 1'b0, 1'b0, 3, 1'b0);

        // R8: valid low with a legal-looking word -> nothing happens
        instr = mk(4, 1'b1, 1, 2, 1'b0, 1'b0); opa = vals[1]; opb = vals[0];
        #1;
        check("R8 idle illegal low", illegal, 1'b0);
        @(negedge clk);
        check("R8 idle cr hold", cr_out, exp_cr);
        check("R9 idle done low", done, 1'b0);

        // R10: reset mid-run clears register
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_cr = '0;
        check("R10 re-reset cr_out", cr_out, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule